// File: doc/BRIEF.md
# Pipelined Synchronous Word SRAM with Byte-Lane Writes

This block is a single-clock synchronous static memory of 32-bit words, written so that an FPGA flow can map each byte lane onto block RAM. Every input (address, write word, lane controls, the three chip selects and the sleep request) is sampled on the rising clock edge. A selected cycle is either a write of one to four byte lanes or a read. A read returns its word through an output register, so the word appears one edge after the cycle was sampled. Address sequencing for bursts is left to an external generator that drives `addr_i`.

Writes can be gated lane by lane through a lane-write qualifier and per-lane enables, or forced to cover the whole word by a global write strobe. A sleep request parks the memory. While it is parked and for a fixed wake-up window after the request is released, the memory accepts no cycle and the read word is forced to zero. The shared data bus is split into `wdata_i` and `rdata_o`. A drive strobe lets the surrounding pad logic build the tristate. The output enable acts only on what is driven and leaves the read pipeline alone. The depth is set by `ADDR_W`. The default is a small 1K-word configuration, and `ADDR_W = 16` gives the full 64K-word array.

Top module: `pipe_sram32`

## Requirements
- R1: A read cycle sampled at edge k places the stored word on `rdata_o` after edge k+1 (with `oe_n_i` low). The word stays there through write and idle cycles until the next accepted read or a sleep cycle replaces it.
- R2: With `gw_n_i` high and `lane_wr_n_i` low, a write updates only the lanes whose `lane_n_i` bit is low. Bit 0 covers data bits 7:0, bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24. All other lanes keep their contents.
- R3: With `gw_n_i` low, a selected cycle writes all four lanes whatever `lane_wr_n_i` and `lane_n_i` are.
- R4: With `gw_n_i` and `lane_wr_n_i` both high, a selected cycle is a read, and `lane_n_i` has no effect on the array.
- R5: A cycle is accepted only when `cs0_n_i` is low, `cs1_i` is high and `cs2_n_i` is low. Any other combination neither writes nor changes `rdata_o`.
- R6: A read sampled on the edge right after a write to the same address returns the newly written word.
- R7: Every cycle sampled with `sleep_i` high is ignored. So are the first 3 cycles sampled with `sleep_i` low after it. The fourth such cycle is accepted normally.
- R8: No write attempted in an ignored sleep or wake-up cycle changes the array. Each such cycle loads zero into the read register one edge later.
- R9: `oe_n_i` high forces `rdata_o` to zero and `drive_o` low. `oe_n_i` low sets `drive_o` high. Neither changes the read register contents.
- R10: After synchronous reset, `rdata_o` reads zero and the memory is awake, so it accepts the first cycle sampled after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_i | input | 1 | Power-down request, active high |
| cs0_n_i | input | 1 | Chip select, active low |
| cs1_i | input | 1 | Chip select, active high |
| cs2_n_i | input | 1 | Chip select, active low |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write word |
| gw_n_i | input | 1 | Global all-lane write, active low |
| lane_wr_n_i | input | 1 | Lane-write qualifier, active low |
| lane_n_i | input | 4 | Per-lane write enables, active low |
| oe_n_i | input | 1 | Output enable, active low |
| rdata_o | output | 32 | Read word, zero when not enabled |
| drive_o | output | 1 | High when the data bus should be driven |

## Verification
The bench goes after the ordering of the decode. A global strobe combined with all lane enables high must still write the whole word, and a lane enable without its qualifier must leave the array untouched. A design with the priority reversed would leave stale lanes, and one that ignores the qualifier would corrupt bytes that later reads expose. The wake-up window is probed one cycle at a time: writes sit on every ignored cycle and a read sits on the first accepted one. A counter that is off by one therefore either lets a write through or drops the read. Back-to-back write and read of one address, selects dropped one at a time, and toggling the output enable across a held word each catch a design that returns old data, accepts deselected cycles, or lets the enable disturb the pipeline.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int unsigned LANE_BITS = 8;

  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2,
    CYC_NAP   = 2'd3
  } cyc_kind_e;
endpackage

// File: rtl/psr_wake.sv
module psr_wake #(
  parameter int unsigned WAKE_CYC = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sleep_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(WAKE_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (sleep_i) begin
      cnt_q <= CW'(WAKE_CYC);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready_o = (cnt_q == '0);

  AST_SLEEP_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> !ready_o); // R7
  AST_READY_STAYS: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !sleep_i) |=> ready_o); // R7
endmodule

// File: rtl/psr_capture.sv
module psr_capture
  import psr_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANES  = 4,
  parameter int unsigned LANE_W = LANE_BITS
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ready_i,
  input  logic                    sleep_i,
  input  logic                    cs0_n_i,
  input  logic                    cs1_i,
  input  logic                    cs2_n_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [LANES*LANE_W-1:0] wdata_i,
  input  logic                    gw_n_i,
  input  logic                    lane_wr_n_i,
  input  logic [LANES-1:0]        lane_n_i,
  output cyc_kind_e               kind_o,
  output logic [LANES-1:0]        mask_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [LANES*LANE_W-1:0] wdata_o
);
  logic             sel;
  logic             nap;
  logic [LANES-1:0] raw_mask;
  logic [LANES-1:0] mask_d;
  cyc_kind_e        kind_d;

  always_comb begin
    sel = !cs0_n_i && cs1_i && !cs2_n_i;
    nap = sleep_i || !ready_i;
    raw_mask = '0;
    if (!gw_n_i) begin
      raw_mask = '1;
    end else if (!lane_wr_n_i) begin
      raw_mask = ~lane_n_i;
    end
    kind_d = CYC_IDLE;
    mask_d = '0;
    if (nap) begin
      kind_d = CYC_NAP;
    end else if (sel) begin
      if (raw_mask != '0) begin
        kind_d = CYC_WRITE;
        mask_d = raw_mask;
      end else begin
        kind_d = CYC_READ;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      kind_o  <= CYC_IDLE;
      mask_o  <= '0;
      addr_o  <= '0;
      wdata_o <= '0;
    end else begin
      kind_o  <= kind_d;
      mask_o  <= mask_d;
      addr_o  <= addr_i;
      wdata_o <= wdata_i;
    end
  end

  AST_FULL_WORD: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && ready_i && !cs0_n_i && cs1_i && !cs2_n_i && !gw_n_i)
      |=> (mask_o == '1)); // R3
  AST_NO_SELECT: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && ready_i && (cs0_n_i || !cs1_i || cs2_n_i))
      |=> (kind_o == CYC_IDLE && mask_o == '0)); // R5
  AST_QUALIFIER_OFF: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && ready_i && !cs0_n_i && cs1_i && !cs2_n_i && gw_n_i && lane_wr_n_i)
      |=> (kind_o == CYC_READ)); // R4
endmodule

// File: rtl/psr_lane_bank.sv
module psr_lane_bank #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned LANE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we_i,
  input  logic              rd_en_i,
  input  logic              blank_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LANE_W-1:0] wdata_i,
  output logic [LANE_W-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) begin
      mem[addr_i] <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || blank_i) begin
      rdata_o <= '0;
    end else if (rd_en_i) begin
      rdata_o <= mem[addr_i];
    end
  end
endmodule

// File: rtl/pipe_sram32.sv
module pipe_sram32
  import psr_pkg::*;
#(
  parameter int unsigned ADDR_W   = 10,
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned WAKE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sleep_i,
  input  logic              cs0_n_i,
  input  logic              cs1_i,
  input  logic              cs2_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gw_n_i,
  input  logic              lane_wr_n_i,
  input  logic [DATA_W/LANE_BITS-1:0] lane_n_i,
  input  logic              oe_n_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              drive_o
);
  localparam int unsigned LANE_W = LANE_BITS;
  localparam int unsigned LANES  = DATA_W / LANE_W;

  logic              ready;
  cyc_kind_e         kind;
  logic [LANES-1:0]  mask;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rd_word;

  psr_wake #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk     (clk),
    .rst     (rst),
    .sleep_i (sleep_i),
    .ready_o (ready)
  );

  psr_capture #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_capture (
    .clk         (clk),
    .rst         (rst),
    .ready_i     (ready),
    .sleep_i     (sleep_i),
    .cs0_n_i     (cs0_n_i),
    .cs1_i       (cs1_i),
    .cs2_n_i     (cs2_n_i),
    .addr_i      (addr_i),
    .wdata_i     (wdata_i),
    .gw_n_i      (gw_n_i),
    .lane_wr_n_i (lane_wr_n_i),
    .lane_n_i    (lane_n_i),
    .kind_o      (kind),
    .mask_o      (mask),
    .addr_o      (addr_q),
    .wdata_o     (wdata_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    psr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk     (clk),
      .rst     (rst),
      .we_i    ((kind == CYC_WRITE) && mask[g]),
      .rd_en_i (kind == CYC_READ),
      .blank_i (kind == CYC_NAP),
      .addr_i  (addr_q),
      .wdata_i (wdata_q[g*LANE_W +: LANE_W]),
      .rdata_o (rd_word[g*LANE_W +: LANE_W])
    );
  end

  assign rdata_o = oe_n_i ? '0 : rd_word;
  assign drive_o = !oe_n_i;

  AST_NAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_NAP) |=> (rd_word == '0)); // R8
  AST_NAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (sleep_i || !ready) |=> (mask == '0)); // R8
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
    (kind == CYC_IDLE || kind == CYC_WRITE) |=> $stable(rd_word)); // R1
endmodule

// File: tb/pipe_sram32_bench.sv
module pipe_sram32_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        sleep;
  logic        cs0_n, cs1, cs2_n;
  logic [9:0]  addr;
  logic [31:0] wdata;
  logic        gw_n, lane_wr_n;
  logic [3:0]  lane_n;
  logic        oe_n;
  logic [31:0] rdata;
  logic        drive;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  string phase = "R10";

  logic [31:0] mem_m [int];
  logic [3:0]  kn_m  [int];
  int          cnt_m;
  bit          p_nap, p_rd;
  logic [3:0]  p_mask;
  logic [9:0]  p_addr;
  logic [31:0] p_data;
  logic [31:0] exp_q;
  bit          exp_known;

  always #10 clk = ~clk;

  pipe_sram32 #(.ADDR_W(10), .DATA_W(32), .WAKE_CYC(3)) u_pipe_sram32 (
    .clk(clk), .rst(rst), .sleep_i(sleep), .cs0_n_i(cs0_n), .cs1_i(cs1),
    .cs2_n_i(cs2_n), .addr_i(addr), .wdata_i(wdata), .gw_n_i(gw_n),
    .lane_wr_n_i(lane_wr_n), .lane_n_i(lane_n), .oe_n_i(oe_n),
    .rdata_o(rdata), .drive_o(drive)
  );

  task automatic model_edge();
    bit nap, sel, ready;
    logic [3:0] raw;
    logic [31:0] w;
    logic [3:0] k;
    if (rst) begin
      cnt_m = 0; p_nap = 0; p_rd = 0; p_mask = '0;
      exp_q = '0; exp_known = 1;
      return;
    end
    if (p_nap) begin
      exp_q = '0; exp_known = 1;
    end else if (p_rd) begin
      if (kn_m.exists(int'(p_addr)) && kn_m[int'(p_addr)] == 4'hF) begin
        exp_q = mem_m[int'(p_addr)]; exp_known = 1;
      end else exp_known = 0;
    end
    if (!p_nap && p_mask != '0) begin
      w = mem_m.exists(int'(p_addr)) ? mem_m[int'(p_addr)] : '0;
      k = kn_m.exists(int'(p_addr)) ? kn_m[int'(p_addr)] : '0;
      for (int i = 0; i < 4; i++)
        if (p_mask[i]) begin
          w[i*8 +: 8] = p_data[i*8 +: 8];
          k[i] = 1'b1;
        end
      mem_m[int'(p_addr)] = w;
      kn_m[int'(p_addr)]  = k;
    end
    ready = (cnt_m == 0);
    nap   = sleep || !ready;
    sel   = !cs0_n && cs1 && !cs2_n;
    raw   = !gw_n ? 4'hF : (!lane_wr_n ? ~lane_n : 4'h0);
    p_nap  = nap;
    p_rd   = !nap && sel && (raw == 4'h0);
    p_mask = (!nap && sel) ? raw : 4'h0;
    p_addr = addr;
    p_data = wdata;
    if (sleep) cnt_m = 3;
    else if (cnt_m > 0) cnt_m--;
  endtask

  task automatic check_out();
    logic [31:0] e;
    e = oe_n ? 32'h0 : exp_q;
    if (exp_known) begin
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s rdata: actual %h expected %h", phase, rdata, e);
      end
    end
    checks++;
    if (drive !== !oe_n) begin
      errors++;
      $display("FAIL R9 drive: actual %b expected %b", drive, !oe_n);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    check_out();
  endtask

  task automatic idle();
    cs0_n = 1'b1; gw_n = 1'b1; lane_wr_n = 1'b1; lane_n = 4'hF;
    tick();
  endtask

  task automatic go(input logic [9:0] a, input logic [31:0] d,
                    input logic g, input logic b, input logic [3:0] ln);
    cs0_n = 1'b0; cs1 = 1'b1; cs2_n = 1'b0;
    addr = a; wdata = d; gw_n = g; lane_wr_n = b; lane_n = ln;
    tick();
  endtask

  task automatic rd(input logic [9:0] a);
    go(a, 32'hDEAD_0000 ^ {22'd0, a}, 1'b1, 1'b1, 4'h0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; sleep = 1'b0; cs0_n = 1'b1; cs1 = 1'b0; cs2_n = 1'b1;
    addr = '0; wdata = '0; gw_n = 1'b1; lane_wr_n = 1'b1; lane_n = 4'hF; oe_n = 1'b0;
    phase = "R10";
    repeat (3) tick();
    rst = 1'b0;
    // R3: global strobe writes all lanes even with every lane enable high
    phase = "R3";
    for (int i = 0; i < 8; i++)
      go(10'(i), 32'h1111_1111 * (i + 1) ^ 32'h5A00_00A5, 1'b0, i[0], 4'hF);
    // R1: back-to-back reads, then held through idle and write cycles
    phase = "R1";
    for (int i = 0; i < 8; i++) rd(10'(i));
    idle(); idle();
    go(10'd30, 32'hCAFE_F00D, 1'b0, 1'b1, 4'hF);
    idle();
    rd(10'd30); idle();
    // R2: lane writes with several masks
    phase = "R2";
    go(10'd3, 32'hAABB_CCDD, 1'b1, 1'b0, 4'b1110); rd(10'd3); idle();
    go(10'd3, 32'h1122_3344, 1'b1, 1'b0, 4'b0111); rd(10'd3); idle();
    go(10'd4, 32'h9988_7766, 1'b1, 1'b0, 4'b1001); rd(10'd4); idle();
    go(10'd5, 32'h0F0F_F0F0, 1'b1, 1'b0, 4'b0000); rd(10'd5); idle();
    // R4: lane enables without qualifier do nothing; cycle is a read
    phase = "R4";
    go(10'd6, 32'hFFFF_FFFF, 1'b1, 1'b1, 4'b0000); idle();
    rd(10'd6); idle();
    // R5: each select dropped alone
    phase = "R5";
    cs0_n = 1'b1; cs1 = 1'b1; cs2_n = 1'b0; addr = 10'd7; wdata = 32'h0BAD_0001;
    gw_n = 1'b0; tick();
    cs0_n = 1'b0; cs1 = 1'b0; tick();
    cs1 = 1'b1; cs2_n = 1'b1; tick();
    cs2_n = 1'b0; gw_n = 1'b1; lane_wr_n = 1'b1; cs0_n = 1'b1; addr = 10'd0; tick();
    rd(10'd7); idle();
    // R6: write then immediate read of same address
    phase = "R6";
    go(10'd9, 32'h600D_BEEF, 1'b0, 1'b1, 4'hF);
    rd(10'd9); idle();
    go(10'd9, 32'h0000_AB00, 1'b1, 1'b0, 4'b1101);
    rd(10'd9); idle();
    // R7 / R8: sleep, wake window with writes, first accepted cycle reads
    phase = "R8";
    go(10'd20, 32'h2020_2020, 1'b0, 1'b1, 4'hF);
    rd(10'd20);
    sleep = 1'b1;
    go(10'd20, 32'hEEEE_0001, 1'b0, 1'b1, 4'hF);
    go(10'd20, 32'hEEEE_0002, 1'b0, 1'b1, 4'hF);
    sleep = 1'b0;
    phase = "R7";
    for (int i = 0; i < 3; i++) go(10'd20, 32'hEEEE_0010 + i, 1'b0, 1'b1, 4'hF);
    rd(10'd20); idle(); idle();
    go(10'd21, 32'h2121_2121, 1'b0, 1'b1, 4'hF);
    rd(10'd21); idle();
    // R9: output enable toggles without touching the pipeline
    phase = "R9";
    oe_n = 1'b1; rd(10'd1); idle();
    oe_n = 1'b0; idle();
    oe_n = 1'b1; idle(); oe_n = 1'b0; idle();
    // R10: reset again clears the read word
    phase = "R10";
    rst = 1'b1; idle(); rst = 1'b0;
    idle();
    rd(10'd2); idle();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule